// File: doc/BRIEF.md
# Multi-register block transfer sequencer

This block runs the bus side of a CPU instruction that moves a group of registers to or from memory with one opcode. The core has eight data registers (indices 0 to 7) and eight address registers (indices 8 to 15). The core hands over the 16-bit opcode, a 16-bit register-select mask, an effective base address that is already computed, and a setting for the CPU generation. The sequencer then issues one memory access per selected register over a request/acknowledge port. It reads store data through a register-file read port and writes loaded values and the updated base register through a register-file write port.

Loads collect every value in an internal buffer. The selected registers are written only after the last read completes, so a fault partway through never leaves the register file half updated. Stores in pre-decrement mode walk the registers in reverse, with the mask bit order flipped, so the data lands in memory in the same layout an ascending transfer would give. Addressing modes the instruction does not allow are rejected with an address fault and no bus activity.

Top module: `regblk_seq`

## Requirements
- R1: Opcode bit 10 sets the direction. When it is 1, memory is read into registers and `mem_we` is 0. When it is 0, registers are written to memory and `mem_we` is 1.
- R2: Opcode bit 6 sets the size. When it is 1, each transfer moves 32 bits with an address step of 4. When it is 0, each transfer moves 16 bits with a step of 2. `mem_size` shows the size. A word store drives the register's low half on `mem_wdata[15:0]` with zeros above it, and leaves the neighbouring halfword in memory unchanged.
- R3: Outside pre-decrement mode, mask bit i (0..7) selects data register i and mask bit i (8..15) selects address register i-8, which is register-file index i. Unselected registers are never written.
- R4: Opcode mode field bits 5:3 equal to 0 or 1 cause a fault. `done` and `addr_fault` are high together in the cycle after `start`, with no memory request, no register write and `busy` low.
- R5: Mode 3 with a store, or mode 4 with a load, faults in the same way as R4.
- R6: In modes 2, 3, 5, 6 and 7, selected registers transfer in ascending index order. The first address is `base_addr`, and each later address is one step higher.
- R7: In mode 4 (store), mask bit j selects register 15-j. Registers are visited from index 15 down to 0, each stored at the running address minus one step. The final address is written to the base register, which is address register opcode[2:0] (index 8+opcode[2:0]).
- R8: After a mode-3 load, the base register receives the address one step past the last transfer. This write follows the loaded values, so it wins over any loaded value for that register.
- R9: A load writes no register until its last read is acknowledged. The selected registers are then written in ascending index order, one per cycle. Word loads are sign-extended from bit 15.
- R10: When a mode-4 store reaches the base register itself, the value stored depends on `late_gen`. With `late_gen` = 1 it is the initial base minus one step. With `late_gen` = 0 it is the initial base.
- R11: An all-zero mask issues no memory access. In modes 3 and 4 the base register is still written, with `base_addr` unchanged.
- R12: `busy` is high from the cycle after an accepted `start` until all transfers and register writes finish. `done` is then high for exactly one cycle, with `busy` low.
- R13: A memory request that is not acknowledged keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged into the next cycle. Each acknowledge completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opcode | input | 16 | Instruction word: direction, size, mode, base register |
| reg_mask | input | 16 | Register-select mask |
| base_addr | input | 32 | Precomputed effective base address |
| late_gen | input | 1 | Generation rule for storing the base register in mode 4 |
| rf_rd_idx | output | 4 | Register-file read index for store data |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_size | output | 1 | 1 = longword, 0 = word |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the current request |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_fault | output | 1 | Illegal mode; high with `done` |

## Verification
The hardest case to reach from the ports is a pre-decrement store that includes its own base register in the mask. Whether that store happens is decided by the reversed bit 7-n of the mask, not bit 8+n. The value it should write depends both on the generation input and on the step size. The stimulus therefore sets the base address register in the bench register file equal to `base_addr`, then selects it through the reversed bit with both generation settings and both sizes. It checks the stored word at the second-highest address, and the final base value returned through the register write port. Acknowledge wait states are inserted on one store, so that a held request can be seen not to produce duplicate transfers.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
    localparam int XLEN  = 32;
    localparam int OPC_W = 16;
    localparam int NREGS = 16;
    localparam int IDXW  = $clog2(NREGS);
    localparam int HALF  = NREGS / 2;
    localparam int WORD  = 16;

    localparam logic [2:0] MODE_DREG    = 3'd0;
    localparam logic [2:0] MODE_AREG    = 3'd1;
    localparam logic [2:0] MODE_POSTINC = 3'd3;
    localparam logic [2:0] MODE_PREDEC  = 3'd4;

    localparam int BIT_DIR  = 10;
    localparam int BIT_SIZE = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XFER,
        S_COMMIT,
        S_BASEWB,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic            is_load;
        logic            is_long;
        logic            predec;
        logic            postinc;
        logic            late_gen;
        logic [IDXW-1:0] base_idx;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] step;
    } xfer_op_t;

    function automatic logic [XLEN-1:0] sext_word(input logic [WORD-1:0] w);
        return {{(XLEN-WORD){w[WORD-1]}}, w};
    endfunction

    function automatic logic [XLEN-1:0] low_word(input logic [XLEN-1:0] v);
        return {{(XLEN-WORD){1'b0}}, v[WORD-1:0]};
    endfunction
endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
    import regblk_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [XLEN-1:0]  base_addr,
    input  logic             late_gen,
    output xfer_op_t         op,
    output logic             illegal
);
    logic [2:0] mode;

    always_comb begin
        mode        = opcode[5:3];
        op.is_load  = opcode[BIT_DIR];
        op.is_long  = opcode[BIT_SIZE];
        op.predec   = (mode == MODE_PREDEC);
        op.postinc  = (mode == MODE_POSTINC);
        op.late_gen = late_gen;
        op.base_idx = IDXW'(HALF) | IDXW'(opcode[2:0]);
        op.base     = base_addr;
        op.step     = opcode[BIT_SIZE] ? XLEN'(4) : XLEN'(2);
        illegal     = (mode == MODE_DREG) || (mode == MODE_AREG)
                    || (op.postinc && !op.is_load)
                    || (op.predec && op.is_load);
    end
endmodule

// File: rtl/regblk_pick.sv
module regblk_pick
    import regblk_pkg::*;
#(
    parameter int N = NREGS,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic         rev,
    output logic         any,
    output logic [N-1:0] sel_oh,
    output logic [W-1:0] idx
);
    logic [W-1:0] pos;
    logic         seen;

    always_comb begin
        seen   = 1'b0;
        sel_oh = '0;
        pos    = '0;
        for (int k = 0; k < N; k++) begin
            if (pend[k] && !seen) begin
                sel_oh[k] = 1'b1;
                pos       = W'(k);
                seen      = 1'b1;
            end
        end
    end

    assign any = |pend;
    assign idx = rev ? (W'(N - 1) - pos) : pos;

    // R6
    pick_sel_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> ($onehot(sel_oh) && ((sel_oh & pend) == sel_oh)));
endmodule

// File: rtl/regblk_ldbuf.sv
module regblk_ldbuf
    import regblk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_en,
    input  logic [IDXW-1:0] cap_idx,
    input  logic [XLEN-1:0] cap_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [XLEN-1:0] rd_data
);
    logic [NREGS-1:0][XLEN-1:0] slots;

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_slot
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (cap_en && cap_idx == IDXW'(g)) begin
                    q <= cap_data;
                end
            end
            assign slots[g] = q;
        end
    endgenerate

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/regblk_seq.sv
module regblk_seq
    import regblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OPC_W-1:0] opcode,
    input  logic [NREGS-1:0] reg_mask,
    input  logic [XLEN-1:0]  base_addr,
    input  logic             late_gen,
    output logic [IDXW-1:0]  rf_rd_idx,
    input  logic [XLEN-1:0]  rf_rd_data,
    output logic             rf_we,
    output logic [IDXW-1:0]  rf_wr_idx,
    output logic [XLEN-1:0]  rf_wr_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_size,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             addr_fault
);
    seq_state_e       state;
    xfer_op_t         op_q;
    xfer_op_t         dec_op;
    logic             dec_bad;
    logic [NREGS-1:0] pend;
    logic [NREGS-1:0] cpend;
    logic [XLEN-1:0]  addr_ptr;
    logic             fault_q;

    logic             x_any;
    logic [NREGS-1:0] x_oh;
    logic [IDXW-1:0]  x_idx;
    logic             c_any;
    logic [NREGS-1:0] c_oh;
    logic [IDXW-1:0]  c_idx;
    logic [XLEN-1:0]  buf_data;
    logic [XLEN-1:0]  store_val;
    logic             cap_en;
    logic [XLEN-1:0]  cap_data;
    seq_state_e       after_xfer;

    regblk_decode u_dec (
        .opcode    (opcode),
        .base_addr (base_addr),
        .late_gen  (late_gen),
        .op        (dec_op),
        .illegal   (dec_bad)
    );

    regblk_pick #(.N(NREGS)) u_xpick (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .rev    (op_q.predec),
        .any    (x_any),
        .sel_oh (x_oh),
        .idx    (x_idx)
    );

    regblk_pick #(.N(NREGS)) u_cpick (
        .clk    (clk),
        .rst    (rst),
        .pend   (cpend),
        .rev    (1'b0),
        .any    (c_any),
        .sel_oh (c_oh),
        .idx    (c_idx)
    );

    regblk_ldbuf u_buf (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_idx  (x_idx),
        .cap_data (cap_data),
        .rd_idx   (c_idx),
        .rd_data  (buf_data)
    );

    always_comb begin
        if (op_q.is_load)     after_xfer = S_COMMIT;
        else if (op_q.predec) after_xfer = S_BASEWB;
        else                  after_xfer = S_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= '0;
            pend     <= '0;
            cpend    <= '0;
            addr_ptr <= '0;
            fault_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q     <= dec_op;
                    pend     <= reg_mask;
                    cpend    <= dec_op.is_load ? reg_mask : '0;
                    addr_ptr <= base_addr;
                    fault_q  <= dec_bad;
                    if (dec_bad)                             state <= S_DONE;
                    else if (reg_mask != '0)                 state <= S_XFER;
                    else if (dec_op.predec || dec_op.postinc) state <= S_BASEWB;
                    else                                     state <= S_DONE;
                end
                S_XFER: if (mem_ack) begin
                    pend     <= pend & ~x_oh;
                    addr_ptr <= op_q.predec ? addr_ptr - op_q.step : addr_ptr + op_q.step;
                    if ((pend & ~x_oh) == '0) state <= after_xfer;
                end
                S_COMMIT: begin
                    cpend <= cpend & ~c_oh;
                    if ((cpend & ~c_oh) == '0) state <= op_q.postinc ? S_BASEWB : S_DONE;
                end
                S_BASEWB: state <= S_DONE;
                default: begin
                    state   <= S_IDLE;
                    fault_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        if (op_q.predec && x_idx == op_q.base_idx)
            store_val = op_q.late_gen ? op_q.base - op_q.step : op_q.base;
        else
            store_val = rf_rd_data;
    end

    assign rf_rd_idx  = x_idx;
    assign mem_req    = (state == S_XFER);
    assign mem_we     = !op_q.is_load;
    assign mem_size   = op_q.is_long;
    assign mem_addr   = op_q.predec ? addr_ptr - op_q.step : addr_ptr;
    assign mem_wdata  = op_q.is_long ? store_val : low_word(store_val);
    assign cap_en     = mem_req && mem_ack && op_q.is_load;
    assign cap_data   = op_q.is_long ? mem_rdata : sext_word(mem_rdata[WORD-1:0]);
    assign rf_we      = (state == S_COMMIT && c_any) || (state == S_BASEWB);
    assign rf_wr_idx  = (state == S_COMMIT) ? c_idx : op_q.base_idx;
    assign rf_wr_data = (state == S_COMMIT) ? buf_data : addr_ptr;
    assign busy       = (state == S_XFER) || (state == S_COMMIT) || (state == S_BASEWB);
    assign done       = (state == S_DONE);
    assign addr_fault = done && fault_q;

    // R4
    fault_now_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && dec_bad) |=> (done && addr_fault && !mem_req && !rf_we));
    // R9
    commit_late_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !mem_req);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R6
    xfer_has_work_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> x_any);
endmodule

// File: tb/regblk_seq_bench.sv
module regblk_seq_bench;
    import regblk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] reg_mask = '0;
    logic [31:0] base_addr = '0;
    logic        late_gen = 1'b0;
    logic [3:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_we;
    logic [3:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, addr_fault;

    logic [31:0] rf [16];
    logic [15:0] mem [1024];

    int checks = 0, errors = 0;
    int wait_cfg = 0, wait_cnt = 0;
    int n_mem = 0, n_rf = 0, mem_at_first_rf = -1;
    bit rf_mid_mem = 0;
    logic [31:0] lg_addr [32];
    logic [31:0] lg_wdata [32];
    logic        lg_we [32];
    logic [3:0]  rl_idx [32];
    logic [31:0] rl_data [32];
    int busy_cycles, done_cycles;
    bit fault_seen, first_busy, post_done, finished = 0;

    regblk_seq u_regblk_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .reg_mask(reg_mask),
        .base_addr(base_addr), .late_gen(late_gen), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .addr_fault(addr_fault)
    );

    always #10 clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];

    always @(negedge clk) begin
        if (rf_we) begin
            if (n_rf == 0) mem_at_first_rf = n_mem;
            if (n_rf < 32) begin
                rl_idx[n_rf]  = rf_wr_idx;
                rl_data[n_rf] = rf_wr_data;
            end
            n_rf++;
            rf[rf_wr_idx] = rf_wr_data;
            if (mem_req) rf_mid_mem = 1;
        end
        if (mem_req) begin
            if (wait_cnt >= wait_cfg) begin
                mem_ack  = 1'b1;
                wait_cnt = 0;
                if (n_mem < 32) begin
                    lg_addr[n_mem]  = mem_addr;
                    lg_wdata[n_mem] = mem_wdata;
                    lg_we[n_mem]    = mem_we;
                end
                n_mem++;
                if (mem_we) begin
                    if (mem_size) begin
                        mem[mem_addr[10:1]]         = mem_wdata[31:16];
                        mem[mem_addr[10:1] + 10'd1] = mem_wdata[15:0];
                    end else begin
                        mem[mem_addr[10:1]] = mem_wdata[15:0];
                    end
                end else begin
                    mem_rdata = mem_size ? {mem[mem_addr[10:1]], mem[mem_addr[10:1] + 10'd1]}
                                         : {16'hA5A5, mem[mem_addr[10:1]]};
                end
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end
    end

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 291 + 4951);
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

    function automatic logic [15:0] mkop(input bit ld, input bit lng, input int mode, input int rg);
        logic [15:0] o;
        o       = 16'h4880;
        o[10]   = ld;
        o[6]    = lng;
        o[5:3]  = 3'(mode);
        o[2:0]  = 3'(rg);
        return o;
    endfunction

    task automatic prime();
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        for (int i = 0; i < 16; i++) rf[i] = 32'h80C0_0000 + 32'(i) * 32'h0001_0101;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] opc, input logic [15:0] msk, input logic [31:0] base,
                          input logic lg, input int wt);
        n_mem = 0; n_rf = 0; mem_at_first_rf = -1; rf_mid_mem = 0;
        busy_cycles = 0; done_cycles = 0; fault_seen = 0; wait_cfg = wt; wait_cnt = 0;
        @(negedge clk);
        opcode = opc; reg_mask = msk; base_addr = base; late_gen = lg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_busy = busy;
        for (int k = 0; k < 400; k++) begin
            if (busy) busy_cycles++;
            if (done) begin
                done_cycles++;
                if (addr_fault) fault_seen = 1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        post_done = done;
        chk("R12", "completion pulse seen", 32'(done_cycles), 32'd1);
    endtask

    task automatic t_reset();
        chk("R12", "reset busy", 32'(busy), 32'd0);
        chk("R12", "reset done", 32'(done), 32'd0);
        chk("R13", "reset mem_req", 32'(mem_req), 32'd0);
        chk("R9", "reset rf_we", 32'(rf_we), 32'd0);
    endtask

    task automatic t_faults();
        bit          lds [4] = '{1, 0, 0, 1};
        int          mds [4] = '{0, 1, 3, 4};
        string       tg  [4] = '{"R4", "R4", "R5", "R5"};
        for (int c = 0; c < 4; c++) begin
            prime();
            run_op(mkop(lds[c], 1, mds[c], 2), 16'h00FF, 32'h100, 1'b1, 0);
            chk(tg[c], "fault flagged", 32'(fault_seen), 32'd1);
            chk(tg[c], "no memory access", 32'(n_mem), 32'd0);
            chk(tg[c], "no register write", 32'(n_rf), 32'd0);
            chk(tg[c], "busy stays low", 32'(busy_cycles), 32'd0);
        end
    endtask

    task automatic t_load_long();
        int regs [4] = '{0, 2, 8, 15};
        logic [31:0] d1;
        prime();
        d1 = rf[1];
        run_op(mkop(1, 1, 2, 1), 16'h8105, 32'h100, 1'b0, 0);
        chk("R6", "load count", 32'(n_mem), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R6", "ascending address", lg_addr[k], 32'h100 + 32'(4 * k));
            chk("R1", "read direction", 32'(lg_we[k]), 32'd0);
            chk("R3", "commit index", 32'(rl_idx[k]), 32'(regs[k]));
            chk("R9", "long value", rl_data[k], {pat(128 + 2 * k), pat(129 + 2 * k)});
        end
        chk("R9", "writes start after last read", 32'(mem_at_first_rf), 32'd4);
        chk("R9", "no write during reads", 32'(rf_mid_mem), 32'd0);
        chk("R3", "unselected register kept", rf[1], d1);
        chk("R12", "busy right after start", 32'(first_busy), 32'd1);
        chk("R12", "busy span", 32'(busy_cycles), 32'd8);
        chk("R12", "done single cycle", 32'(post_done), 32'd0);
        chk("R4", "no fault on legal op", 32'(fault_seen), 32'd0);
    endtask

    task automatic t_load_word_postinc();
        prime();
        mem[10'h100] = 16'h8001;
        run_op(mkop(1, 0, 3, 3), 16'h2802, 32'h200, 1'b0, 0);
        chk("R2", "word step", lg_addr[1], 32'h202);
        chk("R2", "word step last", lg_addr[2], 32'h204);
        chk("R9", "sign extended negative", rf[1], 32'hFFFF_8001);
        chk("R9", "sign extended other", rf[13], sx(pat(16'h102)));
        chk("R8", "write count", 32'(n_rf), 32'd4);
        chk("R8", "base written last", 32'(rl_idx[3]), 32'd11);
        chk("R8", "base final", rf[11], 32'h206);
    endtask

    task automatic t_store_long_wait();
        prime();
        run_op(mkop(0, 1, 5, 0), 16'h0181, 32'h300, 1'b0, 2);
        chk("R13", "one transfer per ack", 32'(n_mem), 32'd3);
        chk("R1", "write direction", 32'(lg_we[0]), 32'd1);
        chk("R6", "first store", {mem[10'h180], mem[10'h181]}, rf[0]);
        chk("R6", "second store", {mem[10'h182], mem[10'h183]}, rf[7]);
        chk("R6", "third store", {mem[10'h184], mem[10'h185]}, rf[8]);
        chk("R6", "no base update", 32'(n_rf), 32'd0);
    endtask

    task automatic t_store_word();
        prime();
        run_op(mkop(0, 0, 2, 0), 16'h0006, 32'h340, 1'b0, 0);
        chk("R2", "word wdata", lg_wdata[0], {16'h0, rf[1][15:0]});
        chk("R2", "word mem 0", 32'(mem[10'h1A0]), 32'(rf[1][15:0]));
        chk("R2", "word mem 1", 32'(mem[10'h1A1]), 32'(rf[2][15:0]));
        chk("R2", "neighbour kept", 32'(mem[10'h1A2]), 32'(pat(16'h1A2)));
    endtask

    task automatic t_predec_late();
        prime();
        rf[10] = 32'h500;
        run_op(mkop(0, 1, 4, 2), 16'h1021, 32'h500, 1'b1, 0);
        chk("R7", "count", 32'(n_mem), 32'd3);
        chk("R7", "first addr", lg_addr[0], 32'h4FC);
        chk("R7", "first data", lg_wdata[0], rf[15]);
        chk("R10", "base store late", lg_wdata[1], 32'h4FC);
        chk("R7", "third addr", lg_addr[2], 32'h4F4);
        chk("R7", "third data", lg_wdata[2], rf[3]);
        chk("R7", "base final", rf[10], 32'h4F4);
    endtask

    task automatic t_predec_early();
        prime();
        rf[10] = 32'h600;
        run_op(mkop(0, 0, 4, 2), 16'h0060, 32'h600, 1'b0, 0);
        chk("R10", "base store early", lg_wdata[0], 32'h0000_0600);
        chk("R7", "early first addr", lg_addr[0], 32'h5FE);
        chk("R7", "second data", lg_wdata[1], {16'h0, rf[9][15:0]});
        chk("R7", "early base final", rf[10], 32'h5FC);
    endtask

    task automatic t_zero_mask();
        prime();
        run_op(mkop(0, 1, 4, 4), 16'h0000, 32'h440, 1'b1, 0);
        chk("R11", "predec no access", 32'(n_mem), 32'd0);
        chk("R11", "predec base write", 32'(n_rf), 32'd1);
        chk("R11", "base unchanged", rf[12], 32'h440);
        prime();
        run_op(mkop(1, 1, 7, 0), 16'h0000, 32'h440, 1'b0, 0);
        chk("R11", "load no access", 32'(n_mem), 32'd0);
        chk("R11", "load no write", 32'(n_rf), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        prime();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_faults();
        t_load_long();
        t_load_word_postinc();
        t_store_long_wait();
        t_store_word();
        t_predec_late();
        t_predec_early();
        t_zero_mask();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule